// File: doc/BRIEF.md
# Dual-Clock Rewind FIFO

This block carries data words from a write port on one free-running clock to a read port on a second clock, which may be unrelated to the first. Each port moves a word only on a rising edge of its own clock. The port must be selected (active low), enabled, and set to its transfer direction. The write side shows an input-ready flag and a programmable almost-full flag. The read side shows an output-ready flag and a programmable almost-empty flag. Both programmable flags are active low, and their thresholds come in as plain inputs.

The read port works in first-word-fall-through style. When output-ready is high, the head word is already on `rdata_o`, and a read consumes that word. A retransmit mode lets a consumer mark the word currently on the output. While the mode is held, the consumer can rewind to the marked word and read the same sequence again. The marked word and everything after it are protected from overwrite, so the writer is stalled once the array has filled back up to the mark.

Pointers cross between the clock domains as Gray codes through two-stage synchronisers. Each flag is a register in the domain of the clock it belongs to.

Top module: `dcf_rewind`

## Requirements
- R1: Words are delivered in write order. With no reads, exactly DEPTH (2^AW) words are accepted, and once the pointers have settled `ir_o` is low exactly when DEPTH words are held. The write pointer and the release pointer each change at most one Gray-code bit per edge of their own clock.
- R2: After a write into an empty FIFO on write edge k (with coincident clocks), `or_o` stays low after read edges k+1 and k+2. It is high after read edge k+3, with the written word already on `rdata_o`.
- R3: `ae_no` is low exactly when the number of stored unread words (including the word on the output) is less than or equal to `ae_off_i`. The flag updates on the read edge after any change.
- R4: `af_no` is low exactly when the number of free locations (DEPTH minus held words) is less than or equal to `af_off_i`. The flag updates on the write edge after any change.
- R5: Retransmit mode is entered on a read edge where `rtm_i` is high and `or_o` is high. That edge marks the word then on `rdata_o`. The mark holds while `rtm_i` stays high, and a read edge with `rtm_i` low leaves the mode. Leaving the mode releases the protected locations, and `ir_o` rises again.
- R6: In retransmit mode, a read edge with `rfm_i` high puts the marked word back on `rdata_o` with `or_o` high. Reading then continues in order from the word after the mark, and `rfm_i` takes priority over a read on the same edge.
- R7: In retransmit mode, `ir_o` goes low once one more write would overwrite the marked word, that is when DEPTH words counted from the mark are held. Further writes are blocked.
- R8: While `rst_ni` is low (held for at least four edges of each clock), `ir_o` and `or_o` are low and `ae_no` is low. `ir_o` rises on the first write edge after reset is released.
- R9: A write needs `wcs_ni` low, `wen_i` high and `wwr_i` high on a write edge. A read needs `rcs_ni` low, `ren_i` high and `rrd_i` high on a read edge. If any one of these qualifiers is wrong, the transfer has no effect.
- R10: A write presented while `ir_o` is low, and a read presented while `or_o` is low, are ignored and move no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-side clock |
| rclk_i | input | 1 | Read-side clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wcs_ni | input | 1 | Write port select, active low |
| wen_i | input | 1 | Write port enable |
| wwr_i | input | 1 | Write port direction, high = write |
| wdata_i | input | DW | Write data |
| ir_o | output | 1 | Input ready (not full) |
| af_no | output | 1 | Almost-full, active low |
| af_off_i | input | AW+1 | Almost-full threshold in free locations |
| rcs_ni | input | 1 | Read port select, active low |
| ren_i | input | 1 | Read port enable |
| rrd_i | input | 1 | Read port direction, high = read |
| rdata_o | output | DW | Head word, valid while or_o is high |
| or_o | output | 1 | Output ready (word present) |
| ae_no | output | 1 | Almost-empty, active low |
| ae_off_i | input | AW+1 | Almost-empty threshold in stored words |
| rtm_i | input | 1 | Retransmit mode request |
| rfm_i | input | 1 | Rewind to the retransmit mark |

## Verification
The assertions take for granted that reset is asserted at time zero. They also assume `rtm_i` stays high for the whole retransmit window, because the rewind check infers the mode from two consecutive high samples of `rtm_i` and `or_o`. The bench drives both ports from one coincident clock, so every synchroniser latency is an exact cycle count. It changes the thresholds only while both ports are idle, and it waits a fixed settling time before checking any flag that depends on a pointer crossing.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int unsigned SYNC_STAGES = 2;

  typedef enum logic [1:0] {
    RD_HOLD,
    RD_LOAD,
    RD_DRAIN,
    RD_REWIND
  } rd_act_e;
endpackage

// File: rtl/dcf_gray2bin.sv
module dcf_gray2bin #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] g_i,
  output logic [W-1:0] b_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_o[i] = ^g_i[W-1:i];
  end
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import dcf_pkg::*;

  logic [W-1:0] stage_q [SYNC_STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(SYNC_STAGES); i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(SYNC_STAGES); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[SYNC_STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 9
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl #(
  parameter int unsigned AW = 9
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_req_i,
  input  logic [AW:0]   rel_gray_i,
  input  logic [AW:0]   af_off_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wptr_gray_o,
  output logic          ir_o,
  output logic          af_no
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] wptr_q, wptr_nxt, wgray_q, rel_bin, used_nxt, free_nxt;
  logic          ir_q, af_n_q;

  dcf_gray2bin #(.W(PW)) u_rel_g2b (.g_i(rel_gray_i), .b_o(rel_bin));

  assign we_o     = wr_req_i & ir_q;
  assign wptr_nxt = wptr_q + {{(PW-1){1'b0}}, we_o};
  assign used_nxt = wptr_nxt - rel_bin;
  assign free_nxt = PW'(DEPTH) - used_nxt;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      wgray_q <= '0;
      ir_q    <= 1'b0;
      af_n_q  <= 1'b1;
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      ir_q    <= used_nxt < PW'(DEPTH);
      af_n_q  <= free_nxt > af_off_i;
    end
  end

  assign waddr_o     = wptr_q[AW-1:0];
  assign wptr_gray_o = wgray_q;
  assign ir_o        = ir_q;
  assign af_no       = af_n_q;
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 9
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_req_i,
  input  logic          rtm_i,
  input  logic          rfm_i,
  input  logic [AW:0]   wptr_gray_i,
  input  logic [AW:0]   ae_off_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] raddr_o,
  output logic [DW-1:0] rdata_o,
  output logic          or_o,
  output logic          ae_no,
  output logic [AW:0]   rel_gray_o
);
  import dcf_pkg::*;

  localparam int unsigned PW = AW + 1;

  logic [PW-1:0] rptr_q, rptr_nxt, mark_q, mark_nxt, rel_q, rel_nxt, rgray_q;
  logic [PW-1:0] wsync, target, count_nxt;
  logic [DW-1:0] dout_q;
  logic          or_q, or_nxt, rt_q, rt_nxt, ae_n_q;
  logic          rd_take, rewind, mem_has, load;
  rd_act_e       act;

  dcf_gray2bin #(.W(PW)) u_w_g2b (.g_i(wptr_gray_i), .b_o(wsync));

  assign rd_take = rd_req_i & or_q;
  assign rewind  = rt_q & rfm_i;
  assign mem_has = wsync != rptr_q;

  always_comb begin
    act = RD_HOLD;
    if (rewind)                act = RD_REWIND;
    else if (!or_q || rd_take) act = mem_has ? RD_LOAD : RD_DRAIN;
  end

  always_comb begin
    rptr_nxt = rptr_q;
    or_nxt   = or_q;
    raddr_o  = rptr_q[AW-1:0];
    unique case (act)
      RD_REWIND: begin
        raddr_o  = mark_q[AW-1:0];
        rptr_nxt = mark_q + PW'(1);
        or_nxt   = 1'b1;
      end
      RD_LOAD: begin
        rptr_nxt = rptr_q + PW'(1);
        or_nxt   = 1'b1;
      end
      RD_DRAIN: or_nxt = 1'b0;
      default:  ;
    endcase
  end

  assign load = (act == RD_LOAD) || (act == RD_REWIND);

  // mark taken only on entry; it names the word on the output
  assign rt_nxt   = rt_q ? rtm_i : (rtm_i & or_q);
  assign mark_nxt = (!rt_q && rtm_i && or_q) ? rptr_q - PW'(1) : mark_q;

  // release pointer walks one step per edge so its Gray code moves one bit
  assign target  = rt_nxt ? mark_nxt : rptr_nxt - {{(PW-1){1'b0}}, or_nxt};
  assign rel_nxt = (rel_q != target) ? rel_q + PW'(1) : rel_q;

  assign count_nxt = wsync - rptr_nxt + {{(PW-1){1'b0}}, or_nxt};

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rptr_q  <= '0;
      mark_q  <= '0;
      rel_q   <= '0;
      rgray_q <= '0;
      or_q    <= 1'b0;
      rt_q    <= 1'b0;
      ae_n_q  <= 1'b0;
    end else begin
      rptr_q  <= rptr_nxt;
      mark_q  <= mark_nxt;
      rel_q   <= rel_nxt;
      rgray_q <= rel_nxt ^ (rel_nxt >> 1);
      or_q    <= or_nxt;
      rt_q    <= rt_nxt;
      ae_n_q  <= count_nxt > ae_off_i;
    end
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni)   dout_q <= '0;
    else if (load) dout_q <= mem_data_i;
  end

  assign rdata_o    = dout_q;
  assign or_o       = or_q;
  assign ae_no      = ae_n_q;
  assign rel_gray_o = rgray_q;
endmodule

// File: rtl/dcf_rewind.sv
module dcf_rewind #(
  parameter int unsigned DW = 36,
  parameter int unsigned AW = 9
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wcs_ni,
  input  logic          wen_i,
  input  logic          wwr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ir_o,
  output logic          af_no,
  input  logic [AW:0]   af_off_i,
  input  logic          rcs_ni,
  input  logic          ren_i,
  input  logic          rrd_i,
  output logic [DW-1:0] rdata_o,
  output logic          or_o,
  output logic          ae_no,
  input  logic [AW:0]   ae_off_i,
  input  logic          rtm_i,
  input  logic          rfm_i
);
  localparam int unsigned PW = AW + 1;

  logic          wr_req, rd_req, we;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_rdata;
  logic [PW-1:0] wptr_gray, wptr_gray_rs, rel_gray, rel_gray_ws;

  assign wr_req = !wcs_ni && wen_i && wwr_i;
  assign rd_req = !rcs_ni && ren_i && rrd_i;

  dcf_wr_ctrl #(.AW(AW)) u_wr (
    .wclk_i      (wclk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_req),
    .rel_gray_i  (rel_gray_ws),
    .af_off_i    (af_off_i),
    .we_o        (we),
    .waddr_o     (waddr),
    .wptr_gray_o (wptr_gray),
    .ir_o        (ir_o),
    .af_no       (af_no)
  );

  dcf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (mem_rdata)
  );

  dcf_sync #(.W(PW)) u_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .d_i    (wptr_gray),
    .q_o    (wptr_gray_rs)
  );

  dcf_sync #(.W(PW)) u_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .d_i    (rel_gray),
    .q_o    (rel_gray_ws)
  );

  dcf_rd_ctrl #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .rd_req_i    (rd_req),
    .rtm_i       (rtm_i),
    .rfm_i       (rfm_i),
    .wptr_gray_i (wptr_gray_rs),
    .ae_off_i    (ae_off_i),
    .mem_data_i  (mem_rdata),
    .raddr_o     (raddr),
    .rdata_o     (rdata_o),
    .or_o        (or_o),
    .ae_no       (ae_no),
    .rel_gray_o  (rel_gray)
  );
endmodule

// File: rtl/dcf_rewind_chk.sv
module dcf_rewind_chk #(
  parameter int unsigned AW = 9
) (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        wcs_ni,
  input logic        wen_i,
  input logic        wwr_i,
  input logic        ir_i,
  input logic        or_i,
  input logic        rtm_i,
  input logic        rfm_i,
  input logic [AW:0] wgray_i,
  input logic [AW:0] rgray_i,
  input logic [AW:0] rgray_ws_i
);
  localparam int unsigned PW    = AW + 1;
  localparam int unsigned DEPTH = 1 << AW;

  logic [PW-1:0] wbin, rbin_ws;

  dcf_gray2bin #(.W(PW)) u_cw (.g_i(wgray_i),    .b_o(wbin));
  dcf_gray2bin #(.W(PW)) u_cr (.g_i(rgray_ws_i), .b_o(rbin_ws));

  // R1
  wgray_step_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_i ^ $past(wgray_i)) <= 1);

  // R1
  relgray_step_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_i ^ $past(rgray_i)) <= 1);

  // R7
  no_overflow_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin - rbin_ws) <= PW'(DEPTH));

  // R10
  wr_block_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wcs_ni && wen_i && wwr_i && !ir_i) |=> $stable(wgray_i));

  // R9
  qualifier_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !(!wcs_ni && wen_i && wwr_i) |=> $stable(wgray_i));

  // R8
  reset_flags_chk: assert property (@(posedge wclk_i)
    !rst_ni |-> (!ir_i && !or_i));

  // R6
  rewind_ready_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rfm_i && rtm_i && $past(rtm_i) && $past(or_i)) |=> or_i);
endmodule

bind dcf_rewind dcf_rewind_chk #(.AW(AW)) u_chk (
  .wclk_i     (wclk_i),
  .rclk_i     (rclk_i),
  .rst_ni     (rst_ni),
  .wcs_ni     (wcs_ni),
  .wen_i      (wen_i),
  .wwr_i      (wwr_i),
  .ir_i       (ir_o),
  .or_i       (or_o),
  .rtm_i      (rtm_i),
  .rfm_i      (rfm_i),
  .wgray_i    (wptr_gray),
  .rgray_i    (rel_gray),
  .rgray_ws_i (rel_gray_ws)
);

// File: tb/dcf_rewind_test.sv
`timescale 1ns/1ps
module dcf_rewind_test;
  localparam int DW = 16;
  localparam int AW = 3;
  localparam int DEPTH = 1 << AW;
  localparam int PW = AW + 1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          wcs_n = 1'b1, wen = 1'b0, wwr = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic          rcs_n = 1'b1, ren = 1'b0, rrd = 1'b0;
  logic          rtm = 1'b0, rfm = 1'b0;
  logic [PW-1:0] ae_off = '0, af_off = '0;
  logic          ir, af_n, orr, ae_n;
  logic [DW-1:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  dcf_rewind #(.DW(DW), .AW(AW)) uut (
    .wclk_i(clk), .rclk_i(clk), .rst_ni(rst_n),
    .wcs_ni(wcs_n), .wen_i(wen), .wwr_i(wwr), .wdata_i(wdata),
    .ir_o(ir), .af_no(af_n), .af_off_i(af_off),
    .rcs_ni(rcs_n), .ren_i(ren), .rrd_i(rrd),
    .rdata_o(rdata), .or_o(orr), .ae_no(ae_n), .ae_off_i(ae_off),
    .rtm_i(rtm), .rfm_i(rfm)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wcs_n = 1'b1; wen = 1'b0; wwr = 1'b0;
    rcs_n = 1'b1; ren = 1'b0; rrd = 1'b0;
    rtm = 1'b0; rfm = 1'b0;
    cyc(5);
    chk("R8 ir in reset", int'(ir), 0);
    chk("R8 or in reset", int'(orr), 0);
    chk("R8 ae in reset", int'(ae_n), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R8 ir after reset", int'(ir), 1);
  endtask

  task automatic wr(input logic [DW-1:0] v);
    wcs_n = 1'b0; wen = 1'b1; wwr = 1'b1; wdata = v;
    cyc(1);
    wcs_n = 1'b1; wen = 1'b0; wwr = 1'b0;
  endtask

  task automatic rd_pulse();
    rcs_n = 1'b0; ren = 1'b1; rrd = 1'b1;
    cyc(1);
    rcs_n = 1'b1; ren = 1'b0; rrd = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input int exp);
    chk({tag, " or"}, int'(orr), 1);
    chk({tag, " data"}, int'(rdata), exp);
    rd_pulse();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // sweep fill level and thresholds: R1 R3 R4 R10
    for (int n = 0; n <= DEPTH; n++) begin
      do_reset();
      for (int i = 0; i < n; i++) wr(DW'(n * 16 + i));
      cyc(8);
      chk("R1 ir at fill", int'(ir), (n < DEPTH) ? 1 : 0);
      chk("R1 or at fill", int'(orr), (n > 0) ? 1 : 0);
      for (int off = 0; off <= DEPTH; off++) begin
        ae_off = PW'(off);
        af_off = PW'(off);
        cyc(2);
        chk("R3 ae", int'(ae_n), (n <= off) ? 0 : 1);
        chk("R4 af", int'(af_n), ((DEPTH - n) <= off) ? 0 : 1);
      end
      if (n == DEPTH) begin
        wr(16'hFFFF);
        cyc(8);
      end
      for (int i = 0; i < n; i++) rd_chk("R1 order", n * 16 + i);
      chk("R10 nothing beyond accepted words", int'(orr), 0);
      rd_pulse();
      cyc(3);
      wr(16'h00C3);
      cyc(8);
      chk("R10 read while empty ignored", int'(rdata), 16'h00C3);
      chk("R10 or after ignored read", int'(orr), 1);
    end

    // R2: output-ready latency
    do_reset();
    cyc(2);
    wr(16'h0077);
    chk("R2 or after edge k", int'(orr), 0);
    cyc(1);
    chk("R2 or after edge k+1", int'(orr), 0);
    cyc(1);
    chk("R2 or after edge k+2", int'(orr), 0);
    cyc(1);
    chk("R2 or after edge k+3", int'(orr), 1);
    chk("R2 data present", int'(rdata), 16'h0077);

    // R9: qualifiers
    do_reset();
    wcs_n = 1'b1; wen = 1'b1; wwr = 1'b1; wdata = 16'h0011; cyc(1);
    wcs_n = 1'b0; wen = 1'b0; wwr = 1'b1; wdata = 16'h0022; cyc(1);
    wcs_n = 1'b0; wen = 1'b1; wwr = 1'b0; wdata = 16'h0033; cyc(1);
    wcs_n = 1'b1; wen = 1'b0; wwr = 1'b0;
    cyc(8);
    chk("R9 unqualified writes", int'(orr), 0);
    wr(16'h0055);
    cyc(8);
    rcs_n = 1'b1; ren = 1'b1; rrd = 1'b1; cyc(1);
    rcs_n = 1'b0; ren = 1'b0; rrd = 1'b1; cyc(1);
    rcs_n = 1'b0; ren = 1'b1; rrd = 1'b0; cyc(1);
    rcs_n = 1'b1; ren = 1'b0; rrd = 1'b0;
    ae_off = '0;
    cyc(2);
    chk("R9 unqualified reads keep word", int'(rdata), 16'h0055);
    chk("R9 unqualified reads keep or", int'(orr), 1);
    chk("R9 count unchanged", int'(ae_n), 1);
    rd_pulse();
    chk("R9 qualified read drains", int'(orr), 0);

    // retransmit: R5 R6 R7
    do_reset();
    for (int i = 0; i < 5; i++) wr(DW'(16'h00A0 + i));
    cyc(8);
    rd_chk("R5 pre-mark", 16'h00A0);
    rtm = 1'b1;
    cyc(1);
    rd_chk("R5 marked word", 16'h00A1);
    rd_chk("R5 in mode", 16'h00A2);
    rd_chk("R5 in mode", 16'h00A3);
    chk("R5 head before rewind", int'(rdata), 16'h00A4);
    rfm = 1'b1;
    rcs_n = 1'b0; ren = 1'b1; rrd = 1'b1;
    cyc(1);
    rfm = 1'b0;
    rcs_n = 1'b1; ren = 1'b0; rrd = 1'b0;
    chk("R6 rewind data", int'(rdata), 16'h00A1);
    chk("R6 rewind or", int'(orr), 1);
    cyc(6);
    chk("R7 room before fill", int'(ir), 1);
    for (int j = 0; j < 4; j++) begin
      wr(DW'(16'h00B0 + j));
      cyc(6);
      chk("R7 ir while refilling", int'(ir), (j < 3) ? 1 : 0);
    end
    wr(16'h00EE);
    cyc(4);
    rtm = 1'b0;
    cyc(1);
    for (int i = 1; i < 5; i++) rd_chk("R6 replay", 16'h00A0 + i);
    for (int j = 0; j < 4; j++) rd_chk("R7 post-mark data", 16'h00B0 + j);
    chk("R7 blocked write absent", int'(orr), 0);
    cyc(16);
    chk("R5 exit releases space", int'(ir), 1);
    ae_off = '0;
    af_off = PW'(DEPTH - 1);
    cyc(2);
    chk("R5 all locations free", int'(af_n), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule